// File: doc/BRIEF.md
# Adaptive Look-Up-Table Predistorter

This block sits in a baseband transmit chain, ahead of the up-converter. It corrects the compression and phase shift of a cheap power amplifier. Each valid complex sample is multiplied by a complex gain. The gain is chosen by the sample's envelope magnitude. Two dual-port tables, indexed by that magnitude, hold the gain: one holds the real part (the scale term) and one holds the imaginary part (the rotation term).

An external estimator compares the amplifier feedback with the transmitted signal. It returns a scale error and a rotation error. The block applies each pair to a table entry with a power-of-two step size. A programmable delay line replays the table address that each sample used. This lets a returning error land on the entry that produced the sample it describes. Updates can be frozen with an enable input. At reset both tables hold unity gain.

Top module: `lut_predist`

## Requirements
- R1: After reset `out_valid` is 0. Every scale entry is 1024 (1.0 with 10 fraction bits) and every rotation entry is 0, so each output sample equals its input sample.
- R2: `out_valid` repeats `in_valid` exactly three clock cycles later. Each output sample belongs to the input sample accepted three cycles earlier.
- R3: The table address of a sample is floor(sqrt(I*I + Q*Q)) shifted right by 5 bits. Samples whose magnitudes give the same address use the same entry; other addresses are unaffected. The largest reachable address is 90.
- R4: With scale S and rotation R read at the sample's address, the output is I' = (I*S − Q*R) >>> 10 and Q' = (I*R + Q*S) >>> 10, using an arithmetic (flooring) shift. Each result is saturated to the range −2048..2047.
- R5: An accepted update sets the addressed scale entry to S − (`err_scale` >>> `mu_shift`). The shift is arithmetic on the signed 12-bit error.
- R6: An accepted update sets the addressed rotation entry to R − (`err_rot` >>> `mu_shift`) in the same cycle as the scale update.
- R7: An update sampled at a clock edge goes to the address of the sample whose output was valid `loop_delay` cycles before that edge's cycle. A value of 0 means the same cycle, and the range is 0 to 63.
- R8: A sample that reads an entry in the same cycle the entry is written gets the old value. The next sample to read that entry gets the new value.
- R9: When `adapt_en` is 0, an asserted `err_valid` changes no table entry.
- R10: Updated entries saturate to −2048..2047 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | Input in-phase sample, signed |
| in_q | input | 12 | Input quadrature sample, signed |
| loop_delay | input | 6 | Feedback loop delay in cycles |
| mu_shift | input | 4 | Step size as a right shift |
| adapt_en | input | 1 | Allows table updates when 1 |
| err_valid | input | 1 | Error pair strobe |
| err_scale | input | 12 | Scale error, signed |
| err_rot | input | 12 | Rotation error, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 12 | Predistorted in-phase sample, signed |
| out_q | output | 12 | Predistorted quadrature sample, signed |

## Verification
The hardest case to reach is an update landing on an entry in the very cycle a later sample reads it. The same holds for an update after a long loop delay, where the wrong replayed address would corrupt a neighbouring entry.

The stimulus sends back-to-back samples with one magnitude and times the error to the cycle the second sample reads the table. It then checks that the second output keeps the old gain and the third shows the new one. For the delay, one sample of one magnitude is followed by a long run at another magnitude, with the error held off for 5 and for 63 cycles. Probes of both magnitudes then show which entry moved.

Saturation of entries is made visible with small-magnitude probes, so that a wrapped gain and a clamped gain give different outputs.

// File: rtl/lut_predist_pkg.sv
package lut_predist_pkg;

    localparam int SW         = 12;             // sample width
    localparam int TW         = 12;             // table word width
    localparam int FRAC       = 10;             // fraction bits of gain
    localparam int AW         = 7;              // table address width
    localparam int DEPTH      = 1 << AW;
    localparam int DLY_W      = 6;
    localparam int MU_W       = 4;
    localparam int ADDR_SHIFT = 5;
    localparam int SUMW       = 2 * SW;
    localparam int RW         = SW;             // root width

    localparam logic signed [TW-1:0] UNITY = TW'(1 << FRAC);
    localparam int TMAX = (1 << (TW - 1)) - 1;
    localparam int TMIN = -(1 << (TW - 1));

    typedef struct packed {
        logic signed [SW-1:0] i;
        logic signed [SW-1:0] q;
    } iq_t;

    // bitwise floor square root, one trial bit per iteration
    function automatic logic [RW-1:0] isqrt(input logic [SUMW-1:0] v);
        logic [RW-1:0]   r;
        logic [RW-1:0]   t;
        logic [SUMW-1:0] sq;
        r = '0;
        for (int b = RW - 1; b >= 0; b--) begin
            t  = r | (RW'(1) << b);
            sq = SUMW'(t) * SUMW'(t);
            if (sq <= v) r = t;
        end
        return r;
    endfunction

    function automatic logic signed [TW-1:0] sat_tw(input int x);
        if (x > TMAX) return TW'(TMAX);
        if (x < TMIN) return TW'(TMIN);
        return TW'(x);
    endfunction

    localparam int MAX_ADDR =
        int'(isqrt(SUMW'(2 * (1 << (SW - 1)) * (1 << (SW - 1)))) >> ADDR_SHIFT);

endpackage

// File: rtl/lut_predist_mag.sv
module lut_predist_mag
    import lut_predist_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  iq_t           in_s,
    output logic          s2_valid,
    output iq_t           s2_s,
    output logic [AW-1:0] s2_addr
);
    logic            s1_valid;
    iq_t             s1_s;
    logic [SUMW-1:0] s1_pwr;
    int              pwr;
    logic [RW-1:0]   root;

    always_comb pwr  = int'(in_s.i) * int'(in_s.i) + int'(in_s.q) * int'(in_s.q);
    always_comb root = isqrt(s1_pwr);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_s     <= '0;
            s1_pwr   <= '0;
            s2_valid <= 1'b0;
            s2_s     <= '0;
            s2_addr  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_s     <= in_s;
            s1_pwr   <= SUMW'(pwr);
            s2_valid <= s1_valid;
            s2_s     <= s1_s;
            s2_addr  <= AW'(root >> ADDR_SHIFT);
        end
    end
endmodule

// File: rtl/lut_predist_table.sv
module lut_predist_table
    import lut_predist_pkg::*;
#(
    parameter logic signed [TW-1:0] INIT = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        raddr,
    output logic signed [TW-1:0] rdata,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic signed [TW-1:0] err,
    input  logic [MU_W-1:0]      mu,
    output logic signed [TW-1:0] wold,
    output logic signed [TW-1:0] wnew
);
    logic signed [TW-1:0] mem [DEPTH];
    logic signed [TW-1:0] step;

    assign rdata = mem[raddr];
    assign wold  = mem[waddr];

    always_comb begin
        step = err >>> mu;
        wnew = sat_tw(int'(wold) - int'(step));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= INIT;
        end else if (we) begin
            mem[waddr] <= wnew;
        end
    end
endmodule

// File: rtl/lut_predist_delay.sv
module lut_predist_delay
    import lut_predist_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr_in,
    input  logic [DLY_W-1:0] sel,
    output logic [AW-1:0]    addr_out
);
    localparam int TAPS = 1 << DLY_W;

    logic [AW-1:0] sr [TAPS];

    always_ff @(posedge clk) begin
        if (rst) sr[0] <= '0;
        else     sr[0] <= addr_in;
    end

    for (genvar k = 1; k < TAPS; k++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) sr[k] <= '0;
            else     sr[k] <= sr[k-1];
        end
    end

    assign addr_out = sr[sel];
endmodule

// File: rtl/lut_predist_cmul.sv
module lut_predist_cmul
    import lut_predist_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  iq_t                  d,
    input  logic signed [TW-1:0] g_s,
    input  logic signed [TW-1:0] g_r,
    output logic                 out_valid,
    output iq_t                  y
);
    int  prod_i;
    int  prod_q;
    iq_t y_n;

    always_comb begin
        prod_i  = int'(d.i) * int'(g_s) - int'(d.q) * int'(g_r);
        prod_q  = int'(d.i) * int'(g_r) + int'(d.q) * int'(g_s);
        y_n.i   = sat_tw(prod_i >>> FRAC);
        y_n.q   = sat_tw(prod_q >>> FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            y         <= '0;
        end else begin
            out_valid <= in_valid;
            y         <= y_n;
        end
    end
endmodule

// File: rtl/lut_predist.sv
module lut_predist
    import lut_predist_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_i,
    input  logic signed [SW-1:0] in_q,
    input  logic [DLY_W-1:0]     loop_delay,
    input  logic [MU_W-1:0]      mu_shift,
    input  logic                 adapt_en,
    input  logic                 err_valid,
    input  logic signed [TW-1:0] err_scale,
    input  logic signed [TW-1:0] err_rot,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_i,
    output logic signed [SW-1:0] out_q
);
    iq_t                  in_s;
    iq_t                  s2_s;
    iq_t                  y;
    logic                 s2_valid;
    logic [AW-1:0]        s2_addr;
    logic [AW-1:0]        fb_addr;
    logic                 upd_en;
    logic signed [TW-1:0] g_s, g_r;
    logic signed [TW-1:0] s_wold, s_wnew, r_wold, r_wnew;

    assign in_s.i = in_i;
    assign in_s.q = in_q;
    assign upd_en = err_valid & adapt_en;

    lut_predist_mag u_mag (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_s(in_s),
        .s2_valid(s2_valid), .s2_s(s2_s), .s2_addr(s2_addr)
    );

    lut_predist_delay u_dly (
        .clk(clk), .rst(rst), .addr_in(s2_addr), .sel(loop_delay),
        .addr_out(fb_addr)
    );

    lut_predist_table #(.INIT(UNITY)) u_scale (
        .clk(clk), .rst(rst), .raddr(s2_addr), .rdata(g_s),
        .we(upd_en), .waddr(fb_addr), .err(err_scale), .mu(mu_shift),
        .wold(s_wold), .wnew(s_wnew)
    );

    lut_predist_table #(.INIT('0)) u_rot (
        .clk(clk), .rst(rst), .raddr(s2_addr), .rdata(g_r),
        .we(upd_en), .waddr(fb_addr), .err(err_rot), .mu(mu_shift),
        .wold(r_wold), .wnew(r_wnew)
    );

    lut_predist_cmul u_mul (
        .clk(clk), .rst(rst), .in_valid(s2_valid), .d(s2_s),
        .g_s(g_s), .g_r(g_r), .out_valid(out_valid), .y(y)
    );

    assign out_i = y.i;
    assign out_q = y.q;
endmodule

// File: rtl/lut_predist_chk.sv
module lut_predist_chk
    import lut_predist_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [AW-1:0]        addr_s2,
    input logic                 upd_en,
    input logic signed [TW-1:0] err_scale,
    input logic signed [TW-1:0] err_rot,
    input logic signed [TW-1:0] s_old,
    input logic signed [TW-1:0] s_new,
    input logic signed [TW-1:0] r_old,
    input logic signed [TW-1:0] r_new
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3) |-> (out_valid == $past(in_valid, 3)));

    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(addr_s2) <= MAX_ADDR);

    // R5
    scale_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !err_scale[TW-1]) |-> (s_new <= s_old));

    // R6
    rot_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && err_rot[TW-1]) |-> (r_new >= r_old));
endmodule

bind lut_predist lut_predist_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .addr_s2(s2_addr), .upd_en(upd_en), .err_scale(err_scale),
    .err_rot(err_rot), .s_old(s_wold), .s_new(s_wnew),
    .r_old(r_wold), .r_new(r_wnew)
);

// File: tb/lut_predist_test.sv
module lut_predist_test;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [11:0] in_i = '0, in_q = '0;
    logic [5:0]        loop_delay = '0;
    logic [3:0]        mu_shift = '0;
    logic              adapt_en = 1'b1;
    logic              err_valid = 1'b0;
    logic signed [11:0] err_scale = '0, err_rot = '0;
    logic              out_valid;
    logic signed [11:0] out_i, out_q;

    int ref_s [128];
    int ref_r [128];
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lut_predist uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .loop_delay(loop_delay), .mu_shift(mu_shift), .adapt_en(adapt_en),
        .err_valid(err_valid), .err_scale(err_scale), .err_rot(err_rot),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int isq(int v);
        int r = 0;
        while ((r + 1) * (r + 1) <= v) r++;
        return r;
    endfunction

    function automatic int clamp(int x);
        if (x > 2047) return 2047;
        if (x < -2048) return -2048;
        return x;
    endfunction

    function automatic int addr_of(int i, int q);
        return isq(i * i + q * q) >>> 5;
    endfunction

    task automatic expect_out(input int i, input int q, output int ei, output int eq);
        int a = addr_of(i, q);
        ei = clamp((i * ref_s[a] - q * ref_r[a]) >>> 10);
        eq = clamp((i * ref_r[a] + q * ref_s[a]) >>> 10);
    endtask

    function automatic void ref_update(int a, int es, int er, int mu);
        ref_s[a] = clamp(ref_s[a] - (es >>> mu));
        ref_r[a] = clamp(ref_r[a] - (er >>> mu));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one sample, checked three cycles later (R2 timing, R4 values)
    task automatic probe(input int i, input int q, input string req);
        int ei, eq;
        expect_out(i, q, ei, eq);
        @(negedge clk); in_valid = 1'b1; in_i = 12'(i); in_q = 12'(q);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); chk("R2 early", int'(out_valid), 0);
        @(negedge clk);
        chk("R2 valid", int'(out_valid), 1);
        chk(req, int'(out_i), ei);
        chk(req, int'(out_q), eq);
    endtask

    // one sample, its error returned after the loop delay
    task automatic apply(input int i, input int q, input int l, input int es,
                         input int er, input int mu, input bit en);
        loop_delay = 6'(l); mu_shift = 4'(mu);
        @(negedge clk); in_valid = 1'b1; in_i = 12'(i); in_q = 12'(q);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        repeat (l) @(negedge clk);
        err_valid = 1'b1; err_scale = 12'(es); err_rot = 12'(er); adapt_en = en;
        @(negedge clk); err_valid = 1'b0; adapt_en = 1'b1;
        if (en) ref_update(addr_of(i, q), es, er, mu);
    endtask

    task automatic t_reset;
        for (int k = 0; k < 128; k++) begin ref_s[k] = 1024; ref_r[k] = 0; end
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_i", int'(out_i), 0);
        probe(300, -400, "R1 unity");
        probe(-2048, -2048, "R3 max address unity");
    endtask

    task automatic t_scale;
        apply(1000, 0, 0, 400, 0, 2, 1'b1);
        probe(1000, 0, "R5 scale");
        probe(0, -1000, "R4 floor same entry");
        probe(0, 500, "R3 other entry");
        apply(1000, 0, 0, -3, 0, 1, 1'b1);
        probe(1000, 0, "R5 negative error shift");
    endtask

    task automatic t_rot;
        apply(0, 700, 0, 0, -512, 0, 1'b1);
        probe(0, 700, "R6 rotation q");
        probe(700, 0, "R4 rotation i");
    endtask

    task automatic t_delay(input int l, input int ai, input int bi);
        loop_delay = 6'(l); mu_shift = '0;
        for (int k = 0; k <= l + 8; k++) begin
            @(negedge clk);
            in_valid = (k <= l + 6);
            in_i = 12'((k == 0) ? ai : bi); in_q = '0;
            err_valid = (k == l + 3); err_scale = 12'(256); err_rot = '0;
        end
        @(negedge clk); in_valid = 1'b0; err_valid = 1'b0;
        ref_update(addr_of(ai, 0), 256, 0, 0);
        probe(ai, 0, "R7 delayed target");
        probe(bi, 0, "R7 neighbour untouched");
    endtask

    task automatic t_read_old;
        int eo, en_, dq;
        loop_delay = '0; mu_shift = 4'd1;
        expect_out(2000, 0, eo, dq);
        ref_update(addr_of(2000, 0), 1024, 0, 1);
        expect_out(2000, 0, en_, dq);
        for (int k = 0; k <= 5; k++) begin
            @(negedge clk);
            if (k == 3) chk("R8 first sample", int'(out_i), eo);
            if (k == 4) chk("R8 read old data", int'(out_i), eo);
            if (k == 5) chk("R8 new data next", int'(out_i), en_);
            in_valid = (k < 3); in_i = 12'(2000); in_q = '0;
            err_valid = (k == 3); err_scale = 12'(1024); err_rot = '0;
        end
        @(negedge clk); in_valid = 1'b0; err_valid = 1'b0;
    endtask

    task automatic t_freeze;
        apply(0, 500, 0, 1000, 600, 0, 1'b0);
        probe(0, 500, "R9 frozen");
    endtask

    task automatic t_sat;
        apply(200, 0, 0, -2048, 0, 0, 1'b1);
        probe(200, 0, "R10 scale clamp high");
        apply(200, 0, 0, 0, 2047, 0, 1'b1);
        apply(200, 0, 0, 0, 2047, 0, 1'b1);
        probe(0, 200, "R10 rotation clamp low");
        apply(1200, 0, 0, -2048, 0, 0, 1'b1);
        probe(1200, 0, "R4 output clamp high");
        probe(-1200, 0, "R4 output clamp low");
    endtask

    initial begin
        t_reset();
        t_scale();
        t_rot();
        t_delay(5, 1600, 320);
        t_delay(63, 1900, 640);
        t_read_old();
        t_freeze();
        t_sat();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL all watchdog actual timeout expected done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule